// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Mode

This block is a 16-bit up-counter that runs from an internal tick or from falling edges on an external count pin. A byte-wide control register drives it. A 16-bit companion register serves two purposes. In reload mode it holds the value loaded back into the counter on overflow. In capture mode it receives a snapshot of the count when the trigger pin falls. Overflows raise a sticky flag, and qualified trigger edges raise a second sticky flag. The interrupt request is the OR of the two flags.

For each direction of a serial port, the block can also act as the baud clock source. Each of two select bits routes either this timer's overflow pulse or an alternate timer's overflow input to that direction's baud output. While either select bit is set, the block runs in baud mode:
- an overflow always reloads the counter, and the capture/reload bit has no say in this;
- the overflow flag is never raised.

Software reaches every register through a small byte-wide bus. Writes are synchronous and reads are combinational.

The mode decode is a combinational enumerated state with four values:
- `MODE_RELOAD`: capture bit 0, both baud selects 0.
- `MODE_CAPTURE`: capture bit 1, both baud selects 0.
- `MODE_BAUD_RELOAD`: a baud select is 1 and the capture bit is 0.
- `MODE_BAUD_CAPTURE`: a baud select is 1 and the capture bit is 1.

The transitions between them happen only on software writes to the control register. Setting either baud select moves the block into a baud state. Clearing both selects returns it to the plain state given by the capture bit. Toggling the capture bit moves the block between the reload and capture variant of the current family.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, the control register, the count and the reload/capture register read as 0, and `ovf_flag_o`, `ext_flag_o` and `irq_o` are 0.
- R2: Control bit 2 (run) and bit 1 (count source, 0 = internal tick) together gate counting. With run 1 and source 0, the count rises by one on each clock edge that sees `tick_i` high. With run 0, ticks leave the count unchanged.
- R3: Bit 7 of the control register (`ovf_flag_o`) is set by an overflow, which is a count step from FFFFh. The flag stays set until software writes the control register with bit 7 at 0. Such a write wins over an overflow in the same cycle.
- R4: In `MODE_RELOAD`, an overflow loads the counter from the reload/capture register.
- R5: In `MODE_CAPTURE`, an overflow wraps the count to 0000h. When bit 3 (trigger enable) is 1, a falling edge on `trg_pin_i` copies the count into the reload/capture register and sets bit 6 (`ext_flag_o`).
- R6: In `MODE_RELOAD` with bit 3 at 1, a falling edge on `trg_pin_i` loads the counter from the reload/capture register and sets bit 6.
- R7: With bit 3 at 0, edges on `trg_pin_i` change neither the count, the reload/capture register nor bit 6.
- R8: When bit 5 (receive baud select) or bit 4 (transmit baud select) is 1, an overflow reloads the counter whatever the value of bit 0 (capture), and bit 7 is not set.
- R9: When bit 5 is 1, `rx_baud_o` carries a one-cycle pulse in the cycle after each overflow; otherwise it follows `alt_ovf_i`. Bit 4 selects `tx_baud_o` the same way.
- R10: With bit 1 at 1 and run at 1, each falling edge on `cnt_pin_i` advances the count exactly once, and `tick_i` is ignored.
- R11: `irq_o` is high exactly when bit 7 or bit 6 is set.
- R12: Register addresses: 0 = control, 1 = count low byte, 2 = count high byte, 3 = reload/capture low byte, 4 = reload/capture high byte. A bus write to the count wins over counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Internal count enable, one step per high cycle |
| cnt_pin_i | input | 1 | External count pin, asynchronous |
| trg_pin_i | input | 1 | External trigger pin, asynchronous |
| alt_ovf_i | input | 1 | Overflow pulse from an alternate timer |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data, combinational |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ext_flag_o | output | 1 | Sticky trigger-event flag |
| irq_o | output | 1 | Interrupt request |
| rx_baud_o | output | 1 | Receive-direction baud clock pulse |
| tx_baud_o | output | 1 | Transmit-direction baud clock pulse |

## Verification
The bench targets the overflow edge in each mode:
- A design that ignored the capture bit outside baud mode would reload instead of wrapping to zero.
- A design that let the capture bit act in baud mode would wrap to zero instead of reloading.
- A design that raised the flag in baud mode would raise a spurious interrupt.

It also clears the overflow flag in the very cycle an overflow occurs. A design that let the hardware set win would leave the flag high.

On the trigger and count pins, it checks that a disabled trigger leaves both registers untouched. It also counts falling edges on the count pin while `tick_i` is held high. A design that counted on levels, counted an edge twice, or kept listening to the tick would end on the wrong count.

// File: rtl/crt_pkg.sv
package crt_pkg;

    typedef enum logic [1:0] {
        MODE_RELOAD,
        MODE_CAPTURE,
        MODE_BAUD_RELOAD,
        MODE_BAUD_CAPTURE
    } mode_e;

    // Control byte, most significant field first.
    typedef struct packed {
        logic ovf;
        logic ext;
        logic rx_baud;
        logic tx_baud;
        logic ext_en;
        logic run;
        logic ext_clk;
        logic capture;
    } ctrl_t;

    function automatic mode_e decode_mode(input logic baud_any, input logic capture);
        mode_e m;
        if (baud_any) begin
            m = capture ? MODE_BAUD_CAPTURE : MODE_BAUD_RELOAD;
        end else begin
            m = capture ? MODE_CAPTURE : MODE_RELOAD;
        end
        return m;
    endfunction

endpackage

// File: rtl/crt_pin_sync.sv
module crt_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    // High on one sample, low on the next: one pulse per edge.
    assign fall_o = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/crt_count_core.sv
module crt_count_core
    import crt_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    localparam int unsigned BYTES = WIDTH / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode_i,
    input  logic             inc_i,
    input  logic             trg_i,
    input  logic [BYTES-1:0] cnt_we_i,
    input  logic [BYTES-1:0] rld_we_i,
    input  logic [7:0]       wdata_i,
    output logic [WIDTH-1:0] count_o,
    output logic [WIDTH-1:0] rld_o,
    output logic             wrap_o
);

    logic [WIDTH-1:0] count_q, count_d;
    logic [WIDTH-1:0] rld_q, rld_d;
    logic             wrap;

    assign wrap = inc_i && (count_q == '1);

    always_comb begin
        count_d = count_q;
        rld_d   = rld_q;
        if (inc_i) begin
            count_d = count_q + 1'b1;
        end
        if (wrap) begin
            unique case (mode_i)
                MODE_CAPTURE:      count_d = '0;
                MODE_RELOAD:       count_d = rld_q;
                MODE_BAUD_RELOAD:  count_d = rld_q;
                MODE_BAUD_CAPTURE: count_d = rld_q;
            endcase
        end
        if (trg_i) begin
            unique case (mode_i)
                MODE_CAPTURE:      rld_d   = count_q;
                MODE_BAUD_CAPTURE: rld_d   = count_q;
                MODE_RELOAD:       count_d = rld_q;
                MODE_BAUD_RELOAD:  count_d = rld_q;
            endcase
        end
        for (int b = 0; b < BYTES; b++) begin
            if (cnt_we_i[b]) count_d[8*b +: 8] = wdata_i;
            if (rld_we_i[b]) rld_d[8*b +: 8]   = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            rld_q   <= '0;
        end else begin
            count_q <= count_d;
            rld_q   <= rld_d;
        end
    end

    assign count_o = count_q;
    assign rld_o   = rld_q;
    assign wrap_o  = wrap;

endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
    import crt_pkg::*;
#(
    parameter int unsigned WIDTH       = 16,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cnt_pin_i,
    input  logic              trg_pin_i,
    input  logic              alt_ovf_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              ovf_flag_o,
    output logic              ext_flag_o,
    output logic              irq_o,
    output logic              rx_baud_o,
    output logic              tx_baud_o
);

    localparam int unsigned BYTES = WIDTH / 8;

    ctrl_t            ctrl_q;
    mode_e            mode;
    logic             ctrl_wr;
    logic [BYTES-1:0] cnt_we;
    logic [BYTES-1:0] rld_we;
    logic             cnt_fall, trg_fall;
    logic             inc, trg_evt, wrap, ovf_set;
    logic             pulse_q;
    logic [WIDTH-1:0] count, rld;

    crt_pin_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(cnt_pin_i), .fall_o(cnt_fall)
    );

    crt_pin_sync #(.STAGES(SYNC_STAGES)) u_trg_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(trg_pin_i), .fall_o(trg_fall)
    );

    assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_W'(0));

    for (genvar b = 0; b < BYTES; b++) begin : g_we
        assign cnt_we[b] = wr_en_i && (wr_addr_i == ADDR_W'(1 + b));
        assign rld_we[b] = wr_en_i && (wr_addr_i == ADDR_W'(1 + BYTES + b));
    end

    assign mode    = decode_mode(ctrl_q.rx_baud | ctrl_q.tx_baud, ctrl_q.capture);
    assign inc     = ctrl_q.run && (ctrl_q.ext_clk ? cnt_fall : tick_i);
    assign trg_evt = ctrl_q.ext_en && trg_fall;

    crt_count_core #(.WIDTH(WIDTH)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .inc_i    (inc),
        .trg_i    (trg_evt),
        .cnt_we_i (cnt_we),
        .rld_we_i (rld_we),
        .wdata_i  (wr_data_i),
        .count_o  (count),
        .rld_o    (rld),
        .wrap_o   (wrap)
    );

    always_comb begin
        ovf_set = 1'b0;
        unique case (mode)
            MODE_RELOAD, MODE_CAPTURE:           ovf_set = wrap;
            MODE_BAUD_RELOAD, MODE_BAUD_CAPTURE: ovf_set = 1'b0;
        endcase
    end

    // A software write decides both flags outright; otherwise hardware may set them.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= wrap;
            if (ctrl_wr) begin
                ctrl_q <= ctrl_t'(wr_data_i);
            end else begin
                if (ovf_set) ctrl_q.ovf <= 1'b1;
                if (trg_evt) ctrl_q.ext <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_W'(0)) rd_data_o = ctrl_q;
        for (int b = 0; b < BYTES; b++) begin
            if (rd_addr_i == ADDR_W'(1 + b))         rd_data_o = count[8*b +: 8];
            if (rd_addr_i == ADDR_W'(1 + BYTES + b)) rd_data_o = rld[8*b +: 8];
        end
    end

    assign ovf_flag_o = ctrl_q.ovf;
    assign ext_flag_o = ctrl_q.ext;
    assign irq_o      = ctrl_q.ovf | ctrl_q.ext;
    assign rx_baud_o  = ctrl_q.rx_baud ? pulse_q : alt_ovf_i;
    assign tx_baud_o  = ctrl_q.tx_baud ? pulse_q : alt_ovf_i;

endmodule

// File: rtl/crt_checker.sv
module crt_checker #(
    parameter int unsigned WIDTH = 16,
    localparam int unsigned BYTES = WIDTH / 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       ctrl,
    input logic             ctrl_wr,
    input logic [BYTES-1:0] cnt_we,
    input logic [WIDTH-1:0] count,
    input logic             ovf_flag_o,
    input logic             ext_flag_o,
    input logic             irq_o
);

    // R3: the overflow flag only falls through a control write
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag_o && !ctrl_wr) |=> ovf_flag_o);

    // R8: no overflow flag rise while a baud select is active
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl[5] || ctrl[4]) && !ctrl_wr && !ovf_flag_o) |=> !ovf_flag_o);

    // R7: trigger disabled leaves the event flag low
    p_ext_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[3] && !ctrl_wr && !ext_flag_o) |=> !ext_flag_o);

    // R2: halted with trigger off and no bus write, the count holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[2] && !ctrl[3] && !ctrl_wr && (cnt_we == '0)) |=> $stable(count));

    // R11: interrupt request agrees with the flags
    p_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ovf_flag_o || ext_flag_o));

    p_irq_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (!ovf_flag_o && !ext_flag_o));

endmodule

bind cap_reload_timer crt_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl_q),
    .ctrl_wr    (ctrl_wr),
    .cnt_we     (cnt_we),
    .count      (count),
    .ovf_flag_o (ovf_flag_o),
    .ext_flag_o (ext_flag_o),
    .irq_o      (irq_o)
);

// File: tb/cap_reload_timer_tb.sv
`timescale 1ns/1ps
module cap_reload_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       cnt_pin_i = 1'b1;
    logic       trg_pin_i = 1'b1;
    logic       alt_ovf_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [2:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic       ovf_flag_o, ext_flag_o, irq_o, rx_baud_o, tx_baud_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cap_reload_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_pin_i(cnt_pin_i),
        .trg_pin_i(trg_pin_i), .alt_ovf_i(alt_ovf_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .ovf_flag_o(ovf_flag_o), .ext_flag_o(ext_flag_o),
        .irq_o(irq_o), .rx_baud_o(rx_baud_o), .tx_baud_o(tx_baud_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] base, input logic [15:0] v);
        wr(base, v[7:0]);
        wr(base + 3'd1, v[15:8]);
    endtask

    task automatic rd16(input logic [2:0] base, output logic [15:0] v);
        rd_addr_i = base; #0.5; v[7:0] = rd_data_o;
        rd_addr_i = base + 3'd1; #0.5; v[15:8] = rd_data_o;
    endtask

    task automatic rd8(input logic [2:0] a, output logic [7:0] v);
        rd_addr_i = a; #0.5; v = rd_data_o;
    endtask

    task automatic ticks(input int n);
        tick_i = 1'b1;
        cyc(n);
        tick_i = 1'b0;
    endtask

    // Expected count after k steps in reload behaviour.
    function automatic logic [15:0] model_count(input logic [15:0] st, input logic [15:0] rl,
                                                input int k);
        logic [15:0] c = st;
        for (int i = 0; i < k; i++) c = (c == 16'hFFFF) ? rl : c + 16'd1;
        return c;
    endfunction

    function automatic bit model_wrapped(input logic [15:0] st, input int k);
        return (32'(st) + 32'(k)) > 32'hFFFF;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v16;
        logic [7:0]  v8;
        cyc(3);
        rst_n = 1'b1;
        cyc(3);

        // R1 reset state
        rd8(3'd0, v8);       check("R1 ctrl", v8, 8'h00);
        rd16(3'd1, v16);     check("R1 count", v16, 16'h0000);
        rd16(3'd3, v16);     check("R1 reload", v16, 16'h0000);
        check("R1 flags", {ovf_flag_o, ext_flag_o, irq_o}, 3'b000);
        cyc(1);

        // R2 and R12 tick counting, then halted
        wr16(3'd1, 16'h0010);
        wr(3'd0, 8'h04);
        ticks(5);
        rd16(3'd1, v16);     check("R2 tick count", v16, 16'h0015);
        cyc(1);
        wr(3'd0, 8'h00);
        ticks(4);
        rd16(3'd1, v16);     check("R2 halted", v16, 16'h0015);
        cyc(1);

        // R4 reload on overflow, R3 flag set and sticky, R11 irq
        wr16(3'd3, 16'hFFF0);
        wr16(3'd1, 16'hFFFE);
        wr(3'd0, 8'h04);
        ticks(3);
        rd16(3'd1, v16);     check("R4 reload on overflow", v16, 16'hFFF1);
        check("R3 flag set", ovf_flag_o, 1'b1);
        check("R11 irq from overflow", irq_o, 1'b1);
        cyc(4);
        rd8(3'd0, v8);       check("R3 flag sticky", v8, 8'h84);
        cyc(1);

        // R3 software clear, then clear in the overflow cycle
        wr(3'd0, 8'h04);
        check("R3 cleared", ovf_flag_o, 1'b0);
        wr16(3'd1, 16'hFFFF);
        wr_en_i = 1'b1; wr_addr_i = 3'd0; wr_data_i = 8'h04; tick_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; tick_i = 1'b0;
        check("R3 write beats set", ovf_flag_o, 1'b0);
        rd16(3'd1, v16);     check("R4 reload same cycle", v16, 16'hFFF0);
        cyc(1);

        // R5 capture on trigger
        wr(3'd0, 8'h00);
        wr16(3'd1, 16'h1234);
        wr(3'd0, 8'h09);
        trg_pin_i = 1'b0;
        cyc(6);
        rd16(3'd3, v16);     check("R5 captured", v16, 16'h1234);
        check("R5 ext flag", ext_flag_o, 1'b1);
        rd8(3'd0, v8);       check("R5 ctrl readback", v8, 8'h49);
        cyc(1);
        trg_pin_i = 1'b1;
        cyc(6);

        // R5 capture-mode overflow wraps to zero
        wr(3'd0, 8'h01);
        wr16(3'd1, 16'hFFFF);
        wr(3'd0, 8'h05);
        ticks(1);
        rd16(3'd1, v16);     check("R5 wrap zero", v16, 16'h0000);
        rd16(3'd3, v16);     check("R5 capture kept", v16, 16'h1234);
        check("R5 overflow flag", ovf_flag_o, 1'b1);
        cyc(1);

        // R7 disabled trigger ignored
        wr(3'd0, 8'h01);
        wr16(3'd1, 16'h4321);
        trg_pin_i = 1'b0;
        cyc(6);
        rd16(3'd3, v16);     check("R7 capture untouched", v16, 16'h1234);
        rd16(3'd1, v16);     check("R7 count untouched", v16, 16'h4321);
        check("R7 ext flag low", ext_flag_o, 1'b0);
        check("R11 irq low", irq_o, 1'b0);
        cyc(1);
        trg_pin_i = 1'b1;
        cyc(6);

        // R6 trigger reload
        wr(3'd0, 8'h00);
        wr16(3'd3, 16'hAAAA);
        wr16(3'd1, 16'h5555);
        wr(3'd0, 8'h08);
        trg_pin_i = 1'b0;
        cyc(6);
        rd16(3'd1, v16);     check("R6 trigger reload", v16, 16'hAAAA);
        check("R6 ext flag", ext_flag_o, 1'b1);
        check("R11 irq from trigger", irq_o, 1'b1);
        cyc(1);
        trg_pin_i = 1'b1;
        cyc(6);

        // R8 and R9 baud mode
        wr(3'd0, 8'h00);
        wr16(3'd3, 16'hFFFD);
        wr16(3'd1, 16'hFFFF);
        alt_ovf_i = 1'b1;
        wr(3'd0, 8'h15);
        check("R9 rx follows alt", rx_baud_o, 1'b1);
        check("R9 tx idle", tx_baud_o, 1'b0);
        ticks(1);
        check("R9 tx pulse", tx_baud_o, 1'b1);
        check("R8 no overflow flag", ovf_flag_o, 1'b0);
        rd16(3'd1, v16);     check("R8 forced reload", v16, 16'hFFFD);
        cyc(1);
        check("R9 tx pulse ends", tx_baud_o, 1'b0);
        wr(3'd0, 8'h20);
        check("R9 rx own pulse low", rx_baud_o, 1'b0);
        check("R9 tx follows alt", tx_baud_o, 1'b1);
        alt_ovf_i = 1'b0;
        cyc(1);

        // R10 external count pin, tick held high and ignored
        wr(3'd0, 8'h00);
        wr16(3'd1, 16'h0000);
        wr(3'd0, 8'h06);
        tick_i = 1'b1;
        for (int i = 0; i < 7; i++) begin
            cnt_pin_i = 1'b0; cyc(4);
            cnt_pin_i = 1'b1; cyc(4);
        end
        cyc(4);
        tick_i = 1'b0;
        rd16(3'd1, v16);     check("R10 pin edges", v16, 16'h0007);
        cyc(1);

        // R2 and R4 random runs
        void'($urandom(32'h5EED_0042));
        for (int it = 0; it < 24; it++) begin
            logic [15:0] rl, st;
            int k;
            int n;
            rl = 16'($urandom);
            st = 16'hFFFF - 16'($urandom % 40);
            n  = 1 + int'($urandom % 60);
            k  = 0;
            wr(3'd0, 8'h00);
            wr16(3'd3, rl);
            wr16(3'd1, st);
            wr(3'd0, 8'h04);
            for (int c = 0; c < n; c++) begin
                tick_i = 1'($urandom % 2);
                if (tick_i) k++;
                @(negedge clk);
            end
            tick_i = 1'b0;
            rd16(3'd1, v16);  check("R4 random count", v16, model_count(st, rl, k));
            check("R3 random flag", ovf_flag_o, model_wrapped(st, k));
            cyc(1);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule